// File: doc/BRIEF.md
# Parallel NOR Command Sequencer

This block takes one high-level flash request at a time and plays it out as the sequence of write cycles that a parallel NOR device needs to see on its asynchronous, SRAM-style bus. Most commands begin with a fixed two-write unlock preamble to magic word addresses. The command byte follows, and for some commands a user address or data word comes after it. Polling the device for completion and reading back identification or query words are left to other logic. This block only produces the command writes.

A requester presents an opcode, a word address and a data word with `req_valid`. The block takes the request only when it is idle and answers with a one-cycle `req_ack`. It then keeps `busy` high while it drives the bus. Each bus write has one setup clock with chip enable low, a write-enable pulse whose length in clocks comes from `wr_pulse` (read when the request is taken), and one hold clock. Command word addresses become byte addresses on the bus by shifting left by log2 of the data width in bytes, which is one bit for the default 16-bit bus.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is held and in the first cycle after release, `bus_ce_n` and `bus_we_n` are 1 and `busy` and `req_ack` are 0.
- R2: Opcode 1 (program) produces four writes in order: 0xAA to word 0x555, 0x55 to word 0x2AA, 0xA0 to word 0x555, then the request data word to the request word address.
- R3: Opcode 4 (identifier mode entry) produces three writes: 0xAA to word 0x555, 0x55 to word 0x2AA, 0x90 to word 0x555.
- R4: Opcode 2 (block erase) produces six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 to the request word address.
- R5: Opcode 3 (chip erase) produces the same first five writes as R4, and its sixth write is 0x10 to word 0x555.
- R6: Opcode 5 (query mode entry) produces exactly one write, 0x98 to word 0x55, with no unlock preamble.
- R7: Opcode 0 (return to read) produces exactly one write, 0xF0 to word 0, with no unlock preamble.
- R8: For a 16-bit data bus, `bus_addr` equals the word address shifted left by one bit, and bit 0 is zero.
- R9: Each write cycle has one setup clock (chip enable low, write enable high, address and data valid). Write enable is then low for exactly N clocks, where N is the value of `wr_pulse` when the request was taken, or 1 if that value is 0. One hold clock follows with write enable high. Address and data stay stable throughout the cycle.
- R10: `req_ack` is a one-cycle pulse in the cycle after acceptance. `busy` is high from that cycle for exactly writes×(N+2) cycles, then returns low.
- R11: A request is not taken while `busy` is high, and opcodes 6 and 7 are never taken. Neither case raises `req_ack` or changes the sequence in progress. A change of `wr_pulse` during a sequence does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Opcode (0 read reset, 1 program, 2 block erase, 3 chip erase, 4 ID entry, 5 query entry) |
| req_waddr | input | WADDR_W (23) | Word address for program data or erase block |
| req_data | input | DATA_W (16) | Data word for program |
| wr_pulse | input | PW_W (4) | Write-enable low time in clocks, 0 treated as 1 |
| req_ack | output | 1 | One-cycle acceptance pulse |
| busy | output | 1 | Sequence in progress |
| bus_addr | output | WADDR_W+1 (24) | Byte address to the device |
| bus_dout | output | DATA_W (16) | Write data to the device |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_we_n | output | 1 | Write enable, active low |

## Verification
Every opcode runs through a scoreboard that holds the expected address/data pairs. The single-write commands with no preamble separate the preamble logic from the command table. The two erase commands share five writes, so running both shows whether the sixth step is selected by opcode. A program request with a non-trivial address and data checks the user-word path and the address shift. Pulse widths of 0, 1, 2, 3, 4 and 15 check the timer limits and the clamping of 0 to 1. A request held high during a sequence, together with a change of `wr_pulse`, shows whether the block latches its inputs. Opcodes 6 and 7 are driven to show that they are rejected.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

   typedef enum logic [2:0] {
      OP_READ_RESET = 3'd0,
      OP_PROGRAM    = 3'd1,
      OP_ERASE_BLK  = 3'd2,
      OP_ERASE_CHIP = 3'd3,
      OP_ID_ENTRY   = 3'd4,
      OP_QRY_ENTRY  = 3'd5
   } seq_op_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_PULSE = 2'd2,
      PH_HOLD  = 2'd3
   } wr_phase_e;

   localparam logic [2:0] OP_LAST_LEGAL = 3'd5;

endpackage

// File: rtl/nor_seq_rom.sv
// Per-step address/data table for each command, computed from opcode and step.
module nor_seq_rom
   import nor_seq_pkg::*;
#(
   parameter int WADDR_W = 23,
   parameter int DATA_W  = 16
)(
   input  seq_op_e              op,
   input  logic [2:0]           step,
   input  logic [WADDR_W-1:0]   usr_waddr,
   input  logic [DATA_W-1:0]    usr_data,
   output logic [WADDR_W-1:0]   cyc_waddr,
   output logic [DATA_W-1:0]    cyc_data,
   output logic                 last_step
);

   localparam logic [WADDR_W-1:0] A_555 = WADDR_W'(12'h555);
   localparam logic [WADDR_W-1:0] A_2AA = WADDR_W'(12'h2AA);
   localparam logic [WADDR_W-1:0] A_055 = WADDR_W'(12'h055);
   localparam logic [WADDR_W-1:0] A_ZERO = '0;

   function automatic logic [DATA_W-1:0] cmd(input logic [7:0] b);
      return DATA_W'(b);
   endfunction

   always_comb begin
      cyc_waddr = A_ZERO;
      cyc_data  = '0;
      last_step = 1'b1;
      unique case (op)
         OP_READ_RESET: begin
            cyc_waddr = A_ZERO;
            cyc_data  = cmd(8'hF0);
         end
         OP_QRY_ENTRY: begin
            cyc_waddr = A_055;
            cyc_data  = cmd(8'h98);
         end
         default: begin
            // shared two-write unlock preamble, then opcode specific tail
            unique case (step)
               3'd0: begin cyc_waddr = A_555; cyc_data = cmd(8'hAA); end
               3'd1: begin cyc_waddr = A_2AA; cyc_data = cmd(8'h55); end
               3'd2: begin
                  cyc_waddr = A_555;
                  unique case (op)
                     OP_PROGRAM:  cyc_data = cmd(8'hA0);
                     OP_ID_ENTRY: cyc_data = cmd(8'h90);
                     default:     cyc_data = cmd(8'h80);
                  endcase
               end
               3'd3: begin
                  if (op == OP_PROGRAM) begin
                     cyc_waddr = usr_waddr;
                     cyc_data  = usr_data;
                  end else begin
                     cyc_waddr = A_555;
                     cyc_data  = cmd(8'hAA);
                  end
               end
               3'd4: begin cyc_waddr = A_2AA; cyc_data = cmd(8'h55); end
               default: begin
                  if (op == OP_ERASE_BLK) begin
                     cyc_waddr = usr_waddr;
                     cyc_data  = cmd(8'h30);
                  end else begin
                     cyc_waddr = A_555;
                     cyc_data  = cmd(8'h10);
                  end
               end
            endcase
            unique case (op)
               OP_ID_ENTRY: last_step = (step == 3'd2);
               OP_PROGRAM:  last_step = (step == 3'd3);
               default:     last_step = (step == 3'd5);
            endcase
         end
      endcase
   end

endmodule

// File: rtl/nor_seq_wgen.sv
// Write-cycle timer: setup, write-enable pulse, hold; steps through the command.
module nor_seq_wgen
   import nor_seq_pkg::*;
#(
   parameter int PW_W = 4
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [PW_W-1:0] pulse_len,
   input  logic            last_step,
   output wr_phase_e       phase,
   output logic [2:0]      step
);

   logic [PW_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         step  <= '0;
         cnt_q <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase <= PH_SETUP;
                  step  <= '0;
               end
            end
            PH_SETUP: begin
               phase <= PH_PULSE;
               cnt_q <= pulse_len;
            end
            PH_PULSE: begin
               if (cnt_q <= PW_W'(1)) phase <= PH_HOLD;
               else                   cnt_q <= cnt_q - PW_W'(1);
            end
            PH_HOLD: begin
               if (last_step) begin
                  phase <= PH_IDLE;
               end else begin
                  phase <= PH_SETUP;
                  step  <= step + 3'd1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_seq_pkg::*;
#(
   parameter int WADDR_W = 23,
   parameter int DATA_W  = 16,
   parameter int PW_W    = 4,
   localparam int SHIFT  = $clog2(DATA_W / 8),
   localparam int ADDR_W = WADDR_W + SHIFT
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [2:0]         req_op,
   input  logic [WADDR_W-1:0] req_waddr,
   input  logic [DATA_W-1:0]  req_data,
   input  logic [PW_W-1:0]    wr_pulse,
   output logic               req_ack,
   output logic               busy,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [DATA_W-1:0]  bus_dout,
   output logic               bus_ce_n,
   output logic               bus_we_n
);

   // elaboration-time parameter checks
   if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32) begin : g_bad_data_w
      $error("nor_cmd_seq: DATA_W must be 8, 16 or 32");
   end
   if (WADDR_W < 12) begin : g_bad_waddr_w
      $error("nor_cmd_seq: WADDR_W must reach word 0x555");
   end
   if (PW_W < 1 || PW_W > 8) begin : g_bad_pw_w
      $error("nor_cmd_seq: PW_W out of range");
   end

   wr_phase_e          phase;
   logic [2:0]         step;
   logic               last_step;
   logic               accept;
   seq_op_e            op_q;
   logic [WADDR_W-1:0] waddr_q;
   logic [DATA_W-1:0]  data_q;
   logic [PW_W-1:0]    pw_q;
   logic [WADDR_W-1:0] cyc_waddr;
   logic [DATA_W-1:0]  cyc_data;

   assign accept = req_valid && (phase == PH_IDLE) && (req_op <= OP_LAST_LEGAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= OP_READ_RESET;
         waddr_q <= '0;
         data_q  <= '0;
         pw_q    <= PW_W'(1);
         req_ack <= 1'b0;
      end else begin
         req_ack <= accept;
         if (accept) begin
            op_q    <= seq_op_e'(req_op);
            waddr_q <= req_waddr;
            data_q  <= req_data;
            pw_q    <= (wr_pulse == '0) ? PW_W'(1) : wr_pulse;
         end
      end
   end

   nor_seq_rom #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_rom (
      .op        (op_q),
      .step      (step),
      .usr_waddr (waddr_q),
      .usr_data  (data_q),
      .cyc_waddr (cyc_waddr),
      .cyc_data  (cyc_data),
      .last_step (last_step)
   );

   nor_seq_wgen #(.PW_W(PW_W)) u_wgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .pulse_len (pw_q),
      .last_step (last_step),
      .phase     (phase),
      .step      (step)
   );

   assign busy     = (phase != PH_IDLE);
   assign bus_ce_n = (phase == PH_IDLE);
   assign bus_we_n = (phase != PH_PULSE);
   assign bus_dout = cyc_data;

   // word-to-byte address conversion chosen by bus width
   if (SHIFT == 0) begin : g_addr_byte
      assign bus_addr = cyc_waddr;
   end else begin : g_addr_wide
      assign bus_addr = {cyc_waddr, {SHIFT{1'b0}}};
   end

endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int PW_W   = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_ack,
   input logic              busy,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_dout,
   input logic              bus_ce_n,
   input logic              bus_we_n
);

   logic [PW_W:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         low_run <= '0;
      else if (!bus_we_n) low_run <= low_run + 1'b1;
      else                low_run <= '0;
   end

   AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bus_ce_n && bus_we_n));                          // R1

   AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we_n |-> !bus_ce_n);                                   // R9

   AST_SETUP_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_we_n) |-> $past(!bus_ce_n));                      // R9

   AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_we_n) |-> !bus_ce_n);                             // R9

   AST_STABLE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we_n && $past(!bus_we_n)) |-> ($stable(bus_addr) && $stable(bus_dout))); // R9

   AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= (PW_W+1)'((1 << PW_W) - 1));                     // R9

   AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);                                      // R10

   AST_ACK_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> (busy && $past(!busy)));                        // R11

   AST_EVEN_BYTE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ce_n && DATA_W == 16) |-> !bus_addr[0]);              // R8

endmodule

bind nor_cmd_seq nor_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PW_W(PW_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ack  (req_ack),
   .busy     (busy),
   .bus_addr (bus_addr),
   .bus_dout (bus_dout),
   .bus_ce_n (bus_ce_n),
   .bus_we_n (bus_we_n)
);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;

   localparam int WADDR_W = 23;
   localparam int DATA_W  = 16;
   localparam int PW_W    = 4;
   localparam int ADDR_W  = WADDR_W + 1;

   typedef struct packed {
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      logic [PW_W-1:0]   pw;
   } wr_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_valid = 1'b0;
   logic [2:0]         req_op = '0;
   logic [WADDR_W-1:0] req_waddr = '0;
   logic [DATA_W-1:0]  req_data = '0;
   logic [PW_W-1:0]    wr_pulse = PW_W'(1);
   logic               req_ack;
   logic               busy;
   logic [ADDR_W-1:0]  bus_addr;
   logic [DATA_W-1:0]  bus_dout;
   logic               bus_ce_n;
   logic               bus_we_n;

   wr_t   exp_q[$];
   wr_t   cur_exp;
   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   logic  prev_we = 1'b1;
   int    low_cnt = 0;

   always #5 clk = ~clk;

   nor_cmd_seq #(.WADDR_W(WADDR_W), .DATA_W(DATA_W), .PW_W(PW_W)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_waddr(req_waddr), .req_data(req_data), .wr_pulse(wr_pulse),
      .req_ack(req_ack), .busy(busy), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [WADDR_W-1:0] wa, input logic [7:0] d8,
                       input logic [DATA_W-1:0] dfull, input bit use_full, input int pw);
      wr_t e;
      e.a  = {wa, 1'b0};                       // R8 word to byte address
      e.d  = use_full ? dfull : DATA_W'(d8);
      e.pw = PW_W'(pw);
      exp_q.push_back(e);
   endtask

   // monitor: each rising write enable is one completed bus write
   always @(negedge clk) begin
      if (rst_n) begin
         if (!bus_we_n) begin
            low_cnt++;
         end else if (!prev_we) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, cur_req, "unexpected write addr", longint'(bus_addr), 0);
            end else begin
               cur_exp = exp_q.pop_front();
               chk(bus_addr == cur_exp.a, cur_req, "write address", longint'(bus_addr), longint'(cur_exp.a));
               chk(bus_dout == cur_exp.d, cur_req, "write data", longint'(bus_dout), longint'(cur_exp.d));
               chk(low_cnt == int'(cur_exp.pw), "R9", "we low clocks", low_cnt, longint'(cur_exp.pw));
            end
            low_cnt = 0;
         end
         prev_we = bus_we_n;
      end
   end

   task automatic run_cmd(input logic [2:0] op, input logic [WADDR_W-1:0] wa,
                          input logic [DATA_W-1:0] d, input int pw,
                          input bit disturb, input string tag);
      int pe;
      int n;
      int cycles;
      pe = (pw == 0) ? 1 : pw;
      cur_req = tag;
      if (op != 3'd0 && op != 3'd5) begin
         push(WADDR_W'(12'h555), 8'hAA, '0, 1'b0, pe);
         push(WADDR_W'(12'h2AA), 8'h55, '0, 1'b0, pe);
      end
      case (op)
         3'd0: push('0, 8'hF0, '0, 1'b0, pe);                       // R7
         3'd5: push(WADDR_W'(12'h055), 8'h98, '0, 1'b0, pe);       // R6
         3'd4: push(WADDR_W'(12'h555), 8'h90, '0, 1'b0, pe);       // R3
         3'd1: begin                                                // R2
            push(WADDR_W'(12'h555), 8'hA0, '0, 1'b0, pe);
            push(wa, 8'h00, d, 1'b1, pe);
         end
         default: begin                                             // R4 R5
            push(WADDR_W'(12'h555), 8'h80, '0, 1'b0, pe);
            push(WADDR_W'(12'h555), 8'hAA, '0, 1'b0, pe);
            push(WADDR_W'(12'h2AA), 8'h55, '0, 1'b0, pe);
            if (op == 3'd2) push(wa, 8'h30, '0, 1'b0, pe);
            else            push(WADDR_W'(12'h555), 8'h10, '0, 1'b0, pe);
         end
      endcase
      n = exp_q.size();
      @(negedge clk);
      req_op = op; req_waddr = wa; req_data = d; wr_pulse = PW_W'(pw); req_valid = 1'b1;
      @(negedge clk);
      chk(req_ack == 1'b1, "R10", "ack after request", req_ack, 1);
      chk(busy == 1'b1, "R10", "busy after request", busy, 1);
      cycles = 1;
      if (!disturb) begin
         req_valid = 1'b0;
      end else begin
         req_op = 3'd3; wr_pulse = PW_W'(7);    // R11 held request and new pulse width
      end
      while (1) begin
         @(negedge clk);
         if (!busy) break;
         cycles++;
         if (disturb) chk(req_ack == 1'b0, "R11", "ack while busy", req_ack, 0);
         if (cycles > 200) break;
      end
      req_valid = 1'b0;
      chk(cycles == n * (pe + 2), "R10", "busy cycles", cycles, n * (pe + 2));
      chk(exp_q.size() == 0, tag, "writes missing", exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      #1_500_000;
      chk(1'b0, "R10", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(bus_ce_n && bus_we_n, "R1", "bus idle in reset", {bus_ce_n, bus_we_n}, 3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_ce_n == 1'b1, "R1", "ce_n after reset", bus_ce_n, 1);
      chk(bus_we_n == 1'b1, "R1", "we_n after reset", bus_we_n, 1);
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(req_ack == 1'b0, "R1", "ack after reset", req_ack, 0);

      run_cmd(3'd1, WADDR_W'(23'h01234), 16'hBEEF, 3, 1'b0, "R2");
      run_cmd(3'd1, WADDR_W'(23'h7FFFFF), 16'h5A0F, 0, 1'b0, "R8");
      run_cmd(3'd4, '0, '0, 1, 1'b0, "R3");
      run_cmd(3'd2, WADDR_W'(23'h040000), '0, 2, 1'b0, "R4");
      run_cmd(3'd3, '0, '0, 15, 1'b0, "R5");
      run_cmd(3'd5, '0, '0, 4, 1'b0, "R6");
      run_cmd(3'd0, '0, '0, 2, 1'b0, "R7");
      run_cmd(3'd1, WADDR_W'(23'h000ABC), 16'h1357, 2, 1'b1, "R11");

      // R11: reserved opcodes are never taken
      for (int k = 6; k < 8; k++) begin
         @(negedge clk);
         req_op = 3'(k); req_valid = 1'b1;
         repeat (3) begin
            @(negedge clk);
            chk(req_ack == 1'b0, "R11", "ack on reserved opcode", req_ack, 0);
            chk(busy == 1'b0 && bus_ce_n == 1'b1, "R11", "activity on reserved opcode",
                {busy, bus_ce_n}, 1);
         end
         req_valid = 1'b0;
      end

      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule